// File: doc/BRIEF.md
# Power-Management Event and System Control Interrupt Controller

This block gathers platform power events (a real-time clock alarm, a power-button press, a global-lock release and a power-management timer overflow) into a status register. It raises a level-sensitive system control interrupt (SCI) while any of those events is both pending and enabled. Software reaches the status register, the enable register and the running timer value through a 64-byte I/O window. The window's base address and its on/off switch come from configuration bytes held elsewhere in the bridge.

The timer is a free-running up-counter that advances on a tick strobe. Its overflow counts as an event only while the timer event is enabled and its pending bit is clear. Pending bits are set by event pulses and cleared by software writing ones. All register reads return data one clock after the read strobe.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, `sci` and `io_rdata` are 0, and the status and enable registers read back as 0x0000 once the window is opened.
- R2: `io_hit` is 1 exactly when `cfg_pmctl[0]` is 1 and `io_addr[15:6]` equals `cfg_pmbase[15:6]`. `cfg_pmbase[31:16]` and `cfg_pmbase[5:0]` have no effect on decoding.
- R3: A one-cycle pulse on `ev_rtc`, `ev_pwrbtn` or `ev_glock` sets status bit 10, 8 or 5 respectively, visible from the next clock. Status is read at window offset 0x00. The timer event is bit 0. All other status bits read 0.
- R4: A write to offset 0x00 clears each status bit whose `io_wdata` bit is 1 and leaves the others unchanged. If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R5: The enable register at offset 0x02 holds all 16 written bits and reads them back unchanged.
- R6: `sci` is 1 exactly while (status AND enable AND 0x0521) is nonzero. It follows a register change from the clock edge that makes the change.
- R7: Each cycle with `tmr_tick` high advances the TMR_W-bit timer by one, wrapping to 0. Offset 0x08 returns bits 15:0 and offset 0x0A returns bits 31:16 of the zero-extended count. Writes to these offsets have no effect.
- R8: A timer wrap sets status bit 0 only when enable bit 0 is 1 and status bit 0 is 0 in that cycle. Otherwise the wrap leaves status unchanged.
- R9: `io_rdata` carries the addressed register in the cycle after `io_rd` is high with `io_hit` high. It is 0 in every other cycle, and 0 for unmapped offsets.
- R10: Writes while `io_hit` is 0, whether the address is outside the window or the window is disabled, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_pmbase | input | 32 | Configuration dword giving the window base (bits 15:6 used) |
| cfg_pmctl | input | 8 | Configuration byte; bit 0 opens the window |
| tmr_tick | input | 1 | Timer advance strobe |
| ev_rtc | input | 1 | Real-time clock alarm event pulse |
| ev_pwrbtn | input | 1 | Power-button event pulse |
| ev_glock | input | 1 | Global-lock event pulse |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 16 | Write data |
| io_hit | output | 1 | Address falls in the open window |
| io_rdata | output | 16 | Read data, one cycle after the strobe |
| sci | output | 1 | Level-sensitive system control interrupt |

## Verification
A wrong pending or enable bit shows on `sci` from the clock after the faulty update. A read of offset 0x00 or 0x02 exposes it one cycle after the read strobe. A timer that counts wrongly, or overflows at the wrong count, shows first as a misplaced rise of status bit 0, and a read of offset 0x08 shows the raw count. Decode faults show immediately on the combinational `io_hit`, and as writes that land or vanish when they should not.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned TMR_POS = 0;
  localparam int unsigned GLK_POS = 5;
  localparam int unsigned PWR_POS = 8;
  localparam int unsigned RTC_POS = 10;

  localparam logic [REG_W-1:0] SCI_MASK =
    REG_W'((1 << TMR_POS) | (1 << GLK_POS) | (1 << PWR_POS) | (1 << RTC_POS));

  localparam logic [5:0] OFS_STS = 6'h00;
  localparam logic [5:0] OFS_ENA = 6'h02;
  localparam logic [5:0] OFS_TLO = 6'h08;
  localparam logic [5:0] OFS_THI = 6'h0A;

  typedef struct packed {
    logic rtc;
    logic pwr;
    logic glk;
    logic tmr;
  } evt_t;

  function automatic logic [REG_W-1:0] evt_to_vec(evt_t e);
    logic [REG_W-1:0] v;
    v = '0;
    v[TMR_POS] = e.tmr;
    v[GLK_POS] = e.glk;
    v[PWR_POS] = e.pwr;
    v[RTC_POS] = e.rtc;
    return v;
  endfunction
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned WIN_LG2 = 6
) (
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic [31:0]        cfg_pmbase,
  input  logic [7:0]         cfg_pmctl,
  output logic               hit,
  output logic [WIN_LG2-1:0] offset
);
  localparam int unsigned TAG_W = ADDR_W - WIN_LG2;

  logic [TAG_W-1:0] base_tag;
  logic [TAG_W-1:0] addr_tag;
  logic             unused_cfg;

  assign base_tag   = cfg_pmbase[ADDR_W-1:WIN_LG2];
  assign addr_tag   = io_addr[ADDR_W-1:WIN_LG2];
  assign unused_cfg = ^{cfg_pmbase[31:ADDR_W], cfg_pmbase[WIN_LG2-1:0], cfg_pmctl[7:1]};

  always_comb begin
    hit    = cfg_pmctl[0] && (addr_tag == base_tag);
    offset = io_addr[WIN_LG2-1:0];
  end
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int unsigned TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [TMR_W-1:0] count,
  output logic             wrap
);
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (tick) begin
      cnt_d = cnt_q + 1'b1;
      wrap  = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_rtc,
  input  logic             ev_pwrbtn,
  input  logic             ev_glock,
  input  logic             tmr_wrap,
  input  logic             sts_we,
  input  logic             ena_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] sts,
  output logic [REG_W-1:0] ena,
  output logic             sci
);
  logic [REG_W-1:0] ena_q;
  logic [REG_W-1:0] ena_d;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic             tmr_armed;
  evt_t             evt;

  // Overflow only counts while the timer event is enabled and not pending.
  assign tmr_armed = ena_q[TMR_POS] & ~sts[TMR_POS];

  always_comb begin
    evt.rtc = ev_rtc;
    evt.pwr = ev_pwrbtn;
    evt.glk = ev_glock;
    evt.tmr = tmr_wrap & tmr_armed;
    set_vec = evt_to_vec(evt);
    clr_vec = sts_we ? (wdata & SCI_MASK) : '0;
    ena_d   = ena_we ? wdata : ena_q;
  end

  genvar b;
  generate
    for (b = 0; b < REG_W; b++) begin : g_sts
      if (SCI_MASK[b]) begin : g_flop
        logic bit_q;
        logic bit_d;
        logic bit_ce;
        always_comb begin
          bit_ce = set_vec[b] | clr_vec[b];
          bit_d  = set_vec[b];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            bit_q <= 1'b0;
          end else if (bit_ce) begin
            bit_q <= bit_d;
          end
        end
        assign sts[b] = bit_q;
      end else begin : g_zero
        assign sts[b] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
    end else if (ena_we) begin
      ena_q <= ena_d;
    end
  end

  assign ena = ena_q;
  assign sci = |(sts & ena_q & SCI_MASK);
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_pmbase,
  input  logic [7:0]        cfg_pmctl,
  input  logic              tmr_tick,
  input  logic              ev_rtc,
  input  logic              ev_pwrbtn,
  input  logic              ev_glock,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [15:0]       io_wdata,
  output logic              io_hit,
  output logic [15:0]       io_rdata,
  output logic              sci
);
  localparam int unsigned WIN_LG2 = 6;

  logic [WIN_LG2-1:0] offset;
  logic [TMR_W-1:0]   tmr_cnt;
  logic [31:0]        tmr_ext;
  logic               tmr_wrap;
  logic [REG_W-1:0]   sts;
  logic [REG_W-1:0]   ena;
  logic               sts_we;
  logic               ena_we;
  logic [15:0]        rd_mux;
  logic [15:0]        rdata_q;
  logic [15:0]        rdata_d;

  pm_win_decode #(.ADDR_W(ADDR_W), .WIN_LG2(WIN_LG2)) u_dec (
    .io_addr    (io_addr),
    .cfg_pmbase (cfg_pmbase),
    .cfg_pmctl  (cfg_pmctl),
    .hit        (io_hit),
    .offset     (offset)
  );

  pm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tmr_tick),
    .count (tmr_cnt),
    .wrap  (tmr_wrap)
  );

  assign sts_we  = io_wr & io_hit & (offset == OFS_STS);
  assign ena_we  = io_wr & io_hit & (offset == OFS_ENA);
  assign tmr_ext = {{(32-TMR_W){1'b0}}, tmr_cnt};

  pm_evt_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_rtc    (ev_rtc),
    .ev_pwrbtn (ev_pwrbtn),
    .ev_glock  (ev_glock),
    .tmr_wrap  (tmr_wrap),
    .sts_we    (sts_we),
    .ena_we    (ena_we),
    .wdata     (io_wdata),
    .sts       (sts),
    .ena       (ena),
    .sci       (sci)
  );

  always_comb begin
    case (offset)
      OFS_STS: rd_mux = sts;
      OFS_ENA: rd_mux = ena;
      OFS_TLO: rd_mux = tmr_ext[15:0];
      OFS_THI: rd_mux = tmr_ext[31:16];
      default: rd_mux = '0;
    endcase
    rdata_d = (io_rd && io_hit) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign io_rdata = rdata_q;
endmodule

// File: rtl/pm_event_ctrl_chk.sv
module pm_event_ctrl_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg_pmbase,
  input logic [7:0]        cfg_pmctl,
  input logic              tmr_tick,
  input logic              ev_rtc,
  input logic              ev_pwrbtn,
  input logic              ev_glock,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic              io_hit,
  input logic [15:0]       io_rdata,
  input logic              sci
);
  // R2
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> cfg_pmctl[0]);

  // R2
  hit_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (io_addr[ADDR_W-1:6] == cfg_pmbase[ADDR_W-1:6]));

  // R9
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(io_rd) |-> (io_rdata == 16'h0000));

  // R6
  sci_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sci) |-> $past(ev_rtc | ev_pwrbtn | ev_glock | io_wr | tmr_tick));

  // R6
  sci_fall_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sci) |-> $past(io_wr));
endmodule

bind pm_event_ctrl pm_event_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_pmbase (cfg_pmbase),
  .cfg_pmctl  (cfg_pmctl),
  .tmr_tick   (tmr_tick),
  .ev_rtc     (ev_rtc),
  .ev_pwrbtn  (ev_pwrbtn),
  .ev_glock   (ev_glock),
  .io_addr    (io_addr),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_hit     (io_hit),
  .io_rdata   (io_rdata),
  .sci        (sci)
);

// File: tb/pm_event_ctrl_bench.sv
module pm_event_ctrl_bench;
  localparam int TW   = 8;
  localparam int TMAX = (1 << TW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_pmbase = 32'h0;
  logic [7:0]  cfg_pmctl = 8'h0;
  logic        tmr_tick = 1'b0;
  logic        ev_rtc = 1'b0, ev_pwrbtn = 1'b0, ev_glock = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_wdata = 16'h0;
  logic        io_hit;
  logic [15:0] io_rdata;
  logic        sci;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pm_event_ctrl #(.ADDR_W(16), .TMR_W(TW)) u_pm_event_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_pmbase(cfg_pmbase), .cfg_pmctl(cfg_pmctl),
    .tmr_tick(tmr_tick), .ev_rtc(ev_rtc), .ev_pwrbtn(ev_pwrbtn), .ev_glock(ev_glock),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_hit(io_hit), .io_rdata(io_rdata), .sci(sci)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Behavioural reference model
  logic [15:0] m_sts, m_en, m_rd;
  int          m_cnt;

  always @(posedge clk or negedge rst_n) begin : model
    if (!rst_n) begin
      m_sts <= 16'h0; m_en <= 16'h0; m_rd <= 16'h0; m_cnt <= 0;
    end else begin
      logic        h;
      int          off;
      logic [15:0] setv, clrv, rv;
      h    = cfg_pmctl[0] && ((io_addr & 16'hFFC0) == (cfg_pmbase[15:0] & 16'hFFC0));
      off  = int'(io_addr & 16'h003F);
      setv = 16'h0;
      if (ev_rtc)    setv = setv | 16'h0400;
      if (ev_pwrbtn) setv = setv | 16'h0100;
      if (ev_glock)  setv = setv | 16'h0020;
      if (tmr_tick && m_cnt == TMAX && m_en[0] && !m_sts[0]) setv = setv | 16'h0001;
      clrv = (io_wr && h && off == 0) ? (io_wdata & 16'h0521) : 16'h0;
      rv = 16'h0;
      if (io_rd && h) begin
        if (off == 0)       rv = m_sts;
        else if (off == 2)  rv = m_en;
        else if (off == 8)  rv = 16'(m_cnt);
        else if (off == 10) rv = 16'(m_cnt >> 16);
      end
      m_sts <= (m_sts & ~clrv) | setv;
      if (io_wr && h && off == 2) m_en <= io_wdata;
      if (tmr_tick) m_cnt <= (m_cnt == TMAX) ? 0 : m_cnt + 1;
      m_rd <= rv;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 sci vs model", 32'(sci), 32'(|(m_sts & m_en & 16'h0521)));
      chk("R9 io_rdata vs model", 32'(io_rdata), 32'(m_rd));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); #1 io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    chk(tag, 32'(io_rdata), 32'(exp));
    #1 io_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    tmr_tick = 1'b1;
    repeat (n) @(negedge clk);
    #1 tmr_tick = 1'b0;
  endtask

  localparam logic [15:0] B = 16'h1240;

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 sci after reset", 32'(sci), 32'h0);
    chk("R1 rdata after reset", 32'(io_rdata), 32'h0);
    io_addr = B;
    #1 chk("R2 hit with window closed", 32'(io_hit), 32'h0);
    // R10 write with window closed
    wr(B + 16'h2, 16'h1234);
    cfg_pmbase = 32'hABCD_1265;
    cfg_pmctl  = 8'hFE;
    io_addr = B;
    #1 chk("R2 bit0 clear keeps window shut", 32'(io_hit), 32'h0);
    cfg_pmctl = 8'h01;
    @(negedge clk); #1;
    rd(B + 16'h0, 16'h0000, "R1 status reset value");
    rd(B + 16'h2, 16'h0000, "R10 R1 enable untouched while closed");
    io_addr = 16'h127F; #1 chk("R2 top of window", 32'(io_hit), 32'h1);
    io_addr = 16'h1280; #1 chk("R2 above window", 32'(io_hit), 32'h0);
    io_addr = 16'h123F; #1 chk("R2 below window", 32'(io_hit), 32'h0);
    // R5 enable register
    wr(B + 16'h2, 16'hFADE);
    rd(B + 16'h2, 16'hFADE, "R5 enable readback");
    // R3 event bits
    ev_rtc = 1'b1; @(negedge clk); #1 ev_rtc = 1'b0;
    rd(B, 16'h0400, "R3 rtc at bit 10");
    chk("R6 no enabled overlap", 32'(sci), 32'h0);
    ev_pwrbtn = 1'b1; @(negedge clk); #1 ev_pwrbtn = 1'b0;
    ev_glock = 1'b1; @(negedge clk); #1 ev_glock = 1'b0;
    rd(B, 16'h0520, "R3 power button and lock bits");
    wr(B + 16'h2, 16'h0100);
    chk("R6 sci with power button enabled", 32'(sci), 32'h1);
    // R4 write-one-to-clear
    wr(B, 16'h0100);
    chk("R6 sci drops after clear", 32'(sci), 32'h0);
    rd(B, 16'h0420, "R4 one clears only its bit");
    wr(B, 16'h0000);
    rd(B, 16'h0420, "R4 zeros leave status");
    ev_pwrbtn = 1'b1; wr(B, 16'h0100); ev_pwrbtn = 1'b0;
    rd(B, 16'h0520, "R4 set beats clear");
    chk("R6 sci after set-over-clear", 32'(sci), 32'h1);
    wr(B, 16'hFFFF);
    rd(B, 16'h0000, "R4 clear all");
    // R9 unmapped offsets
    rd(B + 16'h4, 16'h0000, "R9 unmapped offset 4");
    rd(B + 16'h1, 16'h0000, "R9 odd offset 1");
    rd(16'h2242, 16'h0000, "R9 miss reads zero");
    // R10 writes outside or while closed
    wr(16'h2242, 16'h0000);
    rd(B + 16'h2, 16'h0100, "R10 outside write ignored");
    cfg_pmctl = 8'h00;
    wr(B + 16'h2, 16'h0000);
    cfg_pmctl = 8'h01;
    rd(B + 16'h2, 16'h0100, "R10 closed-window write ignored");
    // R7 timer
    ticks(100);
    rd(B + 16'h8, 16'd100, "R7 timer low word");
    rd(B + 16'hA, 16'h0000, "R7 timer high word");
    wr(B + 16'h8, 16'h0055);
    rd(B + 16'h8, 16'd100, "R7 timer write ignored");
    // R8 wrap without enable
    wr(B + 16'h2, 16'h0000);
    ticks(200);
    rd(B, 16'h0000, "R8 wrap with timer disabled");
    rd(B + 16'h8, 16'd44, "R7 timer wrapped count");
    // R8 wrap with enable
    wr(B + 16'h2, 16'h0001);
    ticks(211);
    rd(B, 16'h0000, "R8 one tick before wrap");
    ticks(1);
    rd(B, 16'h0001, "R8 wrap sets timer bit");
    chk("R6 sci from timer", 32'(sci), 32'h1);
    wr(B, 16'h0001);
    chk("R6 sci after timer clear", 32'(sci), 32'h0);
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule